// File: doc/BRIEF.md
# Instruction Prefetch Queue with Store Snooping

This block sits between an instruction fetch port and the instruction decoder. It keeps a small FIFO of fetched two-byte code units, and each unit carries the linear address of its first byte. The block drives the address of the next unit it wants on `fill_addr`. The fetch source answers on a valid/ready fill stream, and the data it returns must belong to the address shown in that cycle. `fill_ready` drops while the FIFO is full, and the source then holds its beat. The decoder drains the FIFO over a valid/ready stream. `dec_valid` is high whenever a unit is held, and a unit leaves when `dec_valid` and `dec_ready` are both high. Within each unit, the byte at the tagged address is in bits [7:0].

The block also watches every data write the core issues. A write is given as a linear start address and a byte-enable mask, and lane i covers address start+i. If any enabled lane lands on a byte held in the FIFO, or on the beat being accepted in that same cycle, the block discards every entry and resumes fetching at the oldest byte the decoder has not yet taken. The check uses linear addresses only, so a write that reaches the same memory through another linear address does not flush. For that case, a serialize input flushes the queue unconditionally. A branch redirect also flushes, and it restarts fetching at its target. Each flush is reported the next cycle as a one-cycle pulse together with a two-bit cause code.

Top module: `prefetch_snoop_queue`

## Requirements
- R1: During and right after reset, the queue is empty (`dec_valid`=0), `fill_ready`=1, `fill_addr` equals RESET_ADDR and `flush_pulse`=0.
- R2: Units reach the decoder in the order they were filled. `dec_addr` is the unit's first-byte address and `dec_data[7:0]` is the byte at that address. `fill_ready` is 0 exactly when DEPTH units are held, and `fill_addr` advances by 2 on each accepted beat.
- R3: A write with any enabled lane i (address `st_addr`+i, enabled when `st_be[i]`=1) equal to either byte address of any held unit empties the whole queue at the next edge.
- R4: A write whose enabled lanes touch no held byte leaves the queue unchanged. This includes lanes that hit only disabled positions or bytes the decoder already took.
- R5: After a store or serialize flush, `fill_addr` equals the address of the oldest unit not yet consumed. A decoder handshake in the flush cycle counts as consumed, and consumed bytes are not fetched again.
- R6: `serialize`=1 flushes the queue even when it is empty or no write is pending, with cause code 2'b10.
- R7: `redirect_valid`=1 flushes the queue and sets `fill_addr` to `redirect_addr`, with cause code 2'b11.
- R8: A fill beat accepted in a flush cycle is dropped. A write that overlaps only the beat accepted in that cycle also causes a store flush.
- R9: `flush_pulse` is 1 for exactly the cycle after each flushing edge. `flush_cause` is 01 for a store, 10 for serialize, 11 for a branch and 00 otherwise. When several triggers coincide, branch wins over serialize, and serialize wins over store.
- R10: A write that arrives while the queue is empty and no beat is being accepted does not flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fetch source offers a unit for `fill_addr` |
| fill_ready | output | 1 | Queue has room for a unit |
| fill_data | input | 16 | Code unit; low byte belongs to `fill_addr` |
| fill_addr | output | ADDR_W | Linear address of the next unit to fetch |
| dec_valid | output | 1 | Queue holds at least one unit |
| dec_ready | input | 1 | Decoder takes the head unit |
| dec_data | output | 16 | Head unit bytes |
| dec_addr | output | ADDR_W | Linear address of the head unit |
| st_valid | input | 1 | A data write is issued this cycle |
| st_addr | input | ADDR_W | Linear start address of the write |
| st_be | input | 4 | Byte enables; lane i covers `st_addr`+i |
| serialize | input | 1 | Unconditional flush request |
| redirect_valid | input | 1 | Taken branch; flush and restart at target |
| redirect_addr | input | ADDR_W | Branch target linear address (even) |
| flush_pulse | output | 1 | One-cycle flush indication |
| flush_cause | output | 2 | Cause of the indicated flush |

## Verification
The bench builds the block with its default parameters: an 8-entry FIFO of two-byte units, 32-bit addresses and a 4-lane write mask. Write addresses are drawn from a narrow window around the consume point, so writes often straddle unit edges, hit the incoming beat, hit bytes already consumed or hit disabled lanes. The decoder's willingness to accept alternates between slow, medium and fast phases. This takes the FIFO to full back-pressure, to empty, and through flushes that coincide with handshakes on both streams.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_STORE  = 2'b01,
    CAUSE_SERIAL = 2'b10,
    CAUSE_BRANCH = 2'b11
  } flush_cause_e;
endpackage

// File: rtl/pfq_range_match.sv
// Reports whether any enabled write lane lands on any byte of one unit.
module pfq_range_match #(
  parameter int ADDR_W     = 32,
  parameter int UNIT_BYTES = 2,
  parameter int WR_BYTES   = 4
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [WR_BYTES-1:0] st_be,
  output logic              hit
);
  always_comb begin
    hit = 1'b0;
    for (int l = 0; l < WR_BYTES; l++) begin
      for (int b = 0; b < UNIT_BYTES; b++) begin
        if (en && st_be[l] && ((st_addr + ADDR_W'(l)) == (base + ADDR_W'(b))))
          hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfq_fifo.sv
// Circular store of code units with per-slot valid bits and address tags.
module pfq_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    push,
  input  logic [DATA_W-1:0]       push_data,
  input  logic [ADDR_W-1:0]       push_tag,
  input  logic                    pop,
  output logic [DATA_W-1:0]       head_data,
  output logic [ADDR_W-1:0]       head_tag,
  output logic                    full,
  output logic                    empty,
  output logic [DEPTH-1:0]        slot_vld,
  output logic [DEPTH*ADDR_W-1:0] slot_tag_flat
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [ADDR_W-1:0] tag_q  [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      vld_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        vld_q[wr_q] <= 1'b1;
        wr_q        <= step(wr_q);
      end
      if (pop) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= step(rd_q);
      end
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) begin
      data_q[wr_q] <= push_data;
      tag_q[wr_q]  <= push_tag;
    end
  end

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_data = data_q[rd_q];
  assign head_tag  = tag_q[rd_q];
  assign slot_vld  = vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    assign slot_tag_flat[g*ADDR_W +: ADDR_W] = tag_q[g];
  end

  assert_push_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_pop_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_tracks_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));
endmodule

// File: rtl/pfq_snoop.sv
// Compares one write against every held unit and the beat being accepted.
module pfq_snoop #(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int UNIT_BYTES = 2,
  parameter int WR_BYTES   = 4
) (
  input  logic [DEPTH-1:0]        slot_vld,
  input  logic [DEPTH*ADDR_W-1:0] slot_tag_flat,
  input  logic                    beat_vld,
  input  logic [ADDR_W-1:0]       beat_tag,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [WR_BYTES-1:0]     st_be,
  output logic                    hit_queue,
  output logic                    hit_beat
);
  logic [DEPTH-1:0] slot_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    pfq_range_match #(.ADDR_W(ADDR_W), .UNIT_BYTES(UNIT_BYTES), .WR_BYTES(WR_BYTES)) u_cmp (
      .en      (slot_vld[g]),
      .base    (slot_tag_flat[g*ADDR_W +: ADDR_W]),
      .st_addr (st_addr),
      .st_be   (st_be),
      .hit     (slot_hit[g])
    );
  end

  pfq_range_match #(.ADDR_W(ADDR_W), .UNIT_BYTES(UNIT_BYTES), .WR_BYTES(WR_BYTES)) u_beat_cmp (
    .en      (beat_vld),
    .base    (beat_tag),
    .st_addr (st_addr),
    .st_be   (st_be),
    .hit     (hit_beat)
  );

  assign hit_queue = |slot_hit;
endmodule

// File: rtl/prefetch_snoop_queue.sv
module prefetch_snoop_queue #(
  parameter int                DEPTH      = 8,
  parameter int                ADDR_W     = 32,
  parameter int                UNIT_BYTES = 2,
  parameter int                WR_BYTES   = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(4096),
  localparam int               UNIT_W     = UNIT_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_valid,
  output logic                fill_ready,
  input  logic [UNIT_W-1:0]   fill_data,
  output logic [ADDR_W-1:0]   fill_addr,
  output logic                dec_valid,
  input  logic                dec_ready,
  output logic [UNIT_W-1:0]   dec_data,
  output logic [ADDR_W-1:0]   dec_addr,
  input  logic                st_valid,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic [WR_BYTES-1:0] st_be,
  input  logic                serialize,
  input  logic                redirect_valid,
  input  logic [ADDR_W-1:0]   redirect_addr,
  output logic                flush_pulse,
  output logic [1:0]          flush_cause
);
  import pfq_pkg::*;

  localparam logic [ADDR_W-1:0] UNIT_STEP = ADDR_W'(UNIT_BYTES);

  logic               fill_fire, dec_fire;
  logic               q_full, q_empty;
  logic [DEPTH-1:0]   slot_vld;
  logic [DEPTH*ADDR_W-1:0] slot_tag_flat;
  logic               hit_queue, hit_beat, store_hit, flush;
  flush_cause_e       cause_d, cause_q;
  logic               pulse_q;
  logic [ADDR_W-1:0]  fetch_q, consume_q, resume_addr, restart_addr;

  assign fill_ready = !q_full;
  assign dec_valid  = !q_empty;
  assign fill_fire  = fill_valid && fill_ready;
  assign dec_fire   = dec_valid && dec_ready;

  pfq_fifo #(.DEPTH(DEPTH), .DATA_W(UNIT_W), .ADDR_W(ADDR_W)) u_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (flush),
    .push          (fill_fire && !flush),
    .push_data     (fill_data),
    .push_tag      (fetch_q),
    .pop           (dec_fire && !flush),
    .head_data     (dec_data),
    .head_tag      (dec_addr),
    .full          (q_full),
    .empty         (q_empty),
    .slot_vld      (slot_vld),
    .slot_tag_flat (slot_tag_flat)
  );

  pfq_snoop #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .UNIT_BYTES(UNIT_BYTES), .WR_BYTES(WR_BYTES)) u_snoop (
    .slot_vld      (slot_vld),
    .slot_tag_flat (slot_tag_flat),
    .beat_vld      (fill_fire),
    .beat_tag      (fetch_q),
    .st_addr       (st_addr),
    .st_be         (st_be),
    .hit_queue     (hit_queue),
    .hit_beat      (hit_beat)
  );

  assign store_hit = st_valid && (hit_queue || hit_beat);

  always_comb begin
    if (redirect_valid)  cause_d = CAUSE_BRANCH;
    else if (serialize)  cause_d = CAUSE_SERIAL;
    else if (store_hit)  cause_d = CAUSE_STORE;
    else                 cause_d = CAUSE_NONE;
  end

  assign flush        = (cause_d != CAUSE_NONE);
  assign resume_addr  = consume_q + (dec_fire ? UNIT_STEP : '0);
  assign restart_addr = (cause_d == CAUSE_BRANCH) ? redirect_addr : resume_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_q   <= RESET_ADDR;
      consume_q <= RESET_ADDR;
      pulse_q   <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else begin
      pulse_q <= flush;
      cause_q <= cause_d;
      if (flush) begin
        fetch_q   <= restart_addr;
        consume_q <= restart_addr;
      end else begin
        if (fill_fire) fetch_q   <= fetch_q + UNIT_STEP;
        if (dec_fire)  consume_q <= consume_q + UNIT_STEP;
      end
    end
  end

  assign fill_addr   = fetch_q;
  assign flush_pulse = pulse_q;
  assign flush_cause = cause_q;

  assert_branch_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> flush_pulse && (flush_cause == 2'b11) && !dec_valid);
  assert_serial_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (serialize && !redirect_valid) |=> flush_pulse && (flush_cause == 2'b10));
  assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> !dec_valid && fill_ready);
  assert_empty_aligns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (consume_q == fill_addr));
  assert_no_spurious_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_valid && !serialize && !st_valid) |=> !flush_pulse && (flush_cause == 2'b00));
  assert_drop_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_fire && !redirect_valid) |=> (fill_addr == $past(resume_addr)));
endmodule

// File: tb/prefetch_snoop_queue_tb.sv
module prefetch_snoop_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int CYCLES     = 4000;
  localparam logic [31:0] RST_ADDR = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fill_valid, fill_ready;
  logic [15:0] fill_data;
  logic [31:0] fill_addr;
  logic        dec_valid, dec_ready;
  logic [15:0] dec_data;
  logic [31:0] dec_addr;
  logic        st_valid;
  logic [31:0] st_addr;
  logic [3:0]  st_be;
  logic        serialize, redirect_valid;
  logic [31:0] redirect_addr;
  logic        flush_pulse;
  logic [1:0]  flush_cause;

  int n_chk = 0;
  int n_fail = 0;
  int cov [11];
  int unsigned rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_snoop_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data), .fill_addr(fill_addr),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_data(dec_data), .dec_addr(dec_addr),
    .st_valid(st_valid), .st_addr(st_addr), .st_be(st_be),
    .serialize(serialize), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .flush_pulse(flush_pulse), .flush_cause(flush_cause)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [15:0] mem_unit(input logic [31:0] a);
    return {mem_byte(a + 32'd1), mem_byte(a)};
  endfunction

  function automatic bit overlaps(input logic [31:0] base, input logic [31:0] wa, input logic [3:0] be);
    for (int l = 0; l < 4; l++)
      for (int b = 0; b < 2; b++)
        if (be[l] && (wa + 32'(l) == base + 32'(b))) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tag_name(input int t);
    case (t)
      2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";
      8: return "R8";   9: return "R9";   10: return "R10";
      default: return "R?";
    endcase
  endfunction

  function int unsigned rnd(input int unsigned m);
    rng = rng * 32'd1103515245 + 32'd12345;
    return (rng >> 8) % m;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] mq [$];
  logic [31:0] m_fill, m_cons;
  logic        e_pulse;
  logic [1:0]  e_cause;
  int          last_tag, fill_tag;

  always @(posedge clk) fill_data <= 'x;
  always @(negedge clk) fill_data = mem_unit(fill_addr);

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fill_valid = 0; dec_ready = 0; st_valid = 0; st_addr = 0; st_be = 0;
    serialize = 0; redirect_valid = 0; redirect_addr = 0;
    for (int i = 0; i < 11; i++) cov[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dec_valid === 1'b0, "R1", "dec_valid in reset", 32'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dec_valid === 1'b0, "R1", "dec_valid", 32'(dec_valid), 0);
    check(fill_ready === 1'b1, "R1", "fill_ready", 32'(fill_ready), 1);
    check(fill_addr === RST_ADDR, "R1", "fill_addr", fill_addr, RST_ADDR);
    check(flush_pulse === 1'b0, "R1", "flush_pulse", 32'(flush_pulse), 0);
    m_fill = RST_ADDR; m_cons = RST_ADDR; e_pulse = 0; e_cause = 0;
    last_tag = 2; fill_tag = 2;

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      bit fire_in, fire_out, hitq, hitb, snoop;
      int dr, ph;
      logic [31:0] resume;
      // compare outputs against the model
      check(dec_valid === (mq.size() != 0), tag_name(last_tag), "dec_valid", 32'(dec_valid), 32'(mq.size() != 0));
      if (mq.size() != 0) begin
        check(dec_addr === mq[0], tag_name(last_tag), "dec_addr", dec_addr, mq[0]);
        check(dec_data === mem_unit(mq[0]), tag_name(last_tag), "dec_data", 32'(dec_data), 32'(mem_unit(mq[0])));
      end
      check(fill_ready === (mq.size() < DEPTH), tag_name(last_tag), "fill_ready", 32'(fill_ready), 32'(mq.size() < DEPTH));
      check(fill_addr === m_fill, tag_name(fill_tag), "fill_addr", fill_addr, m_fill);
      check(flush_pulse === e_pulse, "R9", "flush_pulse", 32'(flush_pulse), 32'(e_pulse));
      check(flush_cause === e_cause, "R9", "flush_cause", 32'(flush_cause), 32'(e_cause));

      // stimulus
      ph = (cyc / 300) % 3;
      dr = (ph == 0) ? 8 : (ph == 1) ? 2 : 1;
      fill_valid     = (rnd(4) != 0);
      dec_ready      = (ph == 2) ? (rnd(8) != 0) : (rnd(dr) == 0);
      st_valid       = (rnd(3) == 0);
      st_addr        = m_cons + rnd(24) - 32'd6;
      st_be          = 4'(rnd(16));
      serialize      = (rnd(40) == 0);
      redirect_valid = (rnd(40) == 0);
      redirect_addr  = RST_ADDR + (rnd(64) << 1);

      // model next state
      fire_in  = fill_valid && (mq.size() < DEPTH);
      fire_out = dec_ready && (mq.size() != 0);
      hitq = 0;
      foreach (mq[i]) if (overlaps(mq[i], st_addr, st_be)) hitq = 1;
      hitb = fire_in && overlaps(m_fill, st_addr, st_be);
      snoop = st_valid && (hitq || hitb);
      resume = m_cons + (fire_out ? 32'd2 : 32'd0);
      fill_tag = 0;
      if (redirect_valid) begin
        last_tag = 7; e_cause = 2'b11;
      end else if (serialize) begin
        last_tag = 6; e_cause = 2'b10; fill_tag = 5;
      end else if (snoop) begin
        last_tag = fire_in ? 8 : 3; e_cause = 2'b01; fill_tag = 5;
      end else begin
        e_cause = 2'b00;
        if (st_valid) last_tag = (mq.size() == 0 && !fire_in) ? 10 : 4;
        else last_tag = 2;
      end
      e_pulse = (e_cause != 2'b00);
      if (fill_tag == 0) fill_tag = last_tag;
      cov[last_tag]++;
      if (e_pulse) cov[9]++;
      if (fill_tag == 5 && fire_out) cov[5]++;

      if (e_pulse) begin
        mq.delete();
        m_fill = redirect_valid ? redirect_addr : resume;
        m_cons = m_fill;
      end else begin
        if (fire_out) begin void'(mq.pop_front()); m_cons = m_cons + 32'd2; end
        if (fire_in)  begin mq.push_back(m_fill); m_fill = m_fill + 32'd2; end
      end
      @(negedge clk);
    end

    for (int r = 2; r <= 10; r++)
      check(cov[r] > 0, tag_name(r), "scenario reached", 32'(cov[r]), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule